// File: doc/BRIEF.md
# Switch-on-Miss Thread Controller

This block steers coarse-grain multithreading in a short in-order pipeline. A single hardware thread owns the front end until it reports a long-latency event such as a data-cache miss. The controller then flushes the pipeline and records the PC of the instruction that missed as that thread's restart point. It marks the thread as waiting and hands fetch to another thread that is ready. Each thread has its own architected PC, so a thread that was switched out later resumes exactly at the instruction that missed.

Each thread has its own miss-return input, and a pulse on it makes a waiting thread ready again. The next thread is picked in round-robin order, starting with the thread after the one that just left. The pipeline stays silent for a fixed number of flush cycles before any new instruction is fetched. If every thread is waiting, the controller raises a stall indication and fetches nothing. It restarts the cycle after any return arrives.

Top module: `thread_switch_ctrl`

## Requirements
- R1: After reset, thread 0 is active and issuing, fetch_pc equals BOOT_BASE (thread i boots at BOOT_BASE + i*BOOT_STRIDE), flush and stall are low, and no thread is waiting.
- R2: While issue_valid is high and miss_valid is low, the same thread stays active and fetch_pc advances by PC_STEP (4) in the next cycle.
- R3: A miss_valid in an issuing cycle makes flush high for exactly the next cycle only. issue_valid is then low for exactly FLUSH_CYCLES (4) consecutive cycles.
- R4: The miss_pc presented with a miss becomes that thread's restart PC. When the thread next becomes active, its first fetch_pc equals that value.
- R5: At the end of a flush, the new active thread is the first ready thread in the order active+1, active+2, … (wrapping), with the missing thread itself last. A return arriving in that final flush cycle counts as ready.
- R6: If no thread is ready when a flush ends, stall is high and issue_valid is low until a miss-return arrives. In the cycle after that return, issue_valid is high with the round-robin choice active.
- R7: A miss by the active thread and a miss-return for another waiting thread in the same cycle are both applied. The missing thread becomes waiting, and the returning thread becomes eligible at the end of that flush.
- R8: A miss-return for a thread that is not waiting has no effect, and miss_valid is ignored in any cycle in which issue_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Active thread took a long-latency miss this cycle |
| miss_pc | input | PC_W | PC of the instruction that missed |
| ret_valid | input | NTHREADS | Per-thread miss-return pulse |
| active_tid | output | TID_W | Thread currently owning fetch |
| fetch_pc | output | PC_W | Fetch PC of the active thread |
| issue_valid | output | 1 | A valid instruction is fetched this cycle |
| flush | output | 1 | One-cycle pipeline flush pulse |
| stall | output | 1 | No thread is ready; fetch is idle |

## Verification
The hardest case to reach from the ports is the one where every thread is waiting at the same moment. It needs one miss per thread, each timed to an issuing cycle of a different thread, with no returns in between. Directed code gets there by waiting, cycle by cycle, until the bench's own model reports an issuing cycle, then raising a miss, and doing this once for each thread. Further directed steps overlap a miss with a return, pulse returns on threads that are not waiting, and raise misses during a flush. Seeded random misses and returns then cover the remaining interleavings of flush ends, returns and round-robin wraparound.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_FLUSH = 2'd1,
    ST_IDLE  = 2'd2
  } tsc_state_e;
endpackage

// File: rtl/tsc_rr_pick.sv
module tsc_rr_pick #(
  parameter int N     = 4,
  parameter int TID_W = 2
) (
  input  logic [N-1:0]     req,
  input  logic [TID_W-1:0] last,
  output logic             gnt_vld,
  output logic [TID_W-1:0] gnt_id
);
  // Scan from the farthest candidate to the nearest so the nearest wins.
  always_comb begin
    int idx;
    gnt_vld = 1'b0;
    gnt_id  = '0;
    idx     = 0;
    for (int k = N; k >= 1; k--) begin
      idx = int'(last) + k;
      if (idx >= N) idx = idx - N;
      if (req[idx]) begin
        gnt_vld = 1'b1;
        gnt_id  = TID_W'(idx);
      end
    end
  end
endmodule

// File: rtl/tsc_pc_file.sv
module tsc_pc_file #(
  parameter int              N           = 4,
  parameter int              PC_W        = 32,
  parameter int              TID_W       = 2,
  parameter int              PC_STEP     = 4,
  parameter logic [PC_W-1:0] BOOT_BASE   = 'h1000,
  parameter logic [PC_W-1:0] BOOT_STRIDE = 'h1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic             load_en,
  input  logic [TID_W-1:0] sel_id,
  input  logic [PC_W-1:0]  load_pc,
  output logic [PC_W-1:0]  rd_pc
);
  logic [PC_W-1:0] pc_q [N];
  logic [PC_W-1:0] pc_d [N];
  logic [N-1:0]    wr_en;

  for (genvar i = 0; i < N; i++) begin : g_thr
    always_comb begin
      wr_en[i] = (step_en || load_en) && (sel_id == TID_W'(i));
      pc_d[i]  = load_en ? load_pc : pc_q[i] + PC_W'(PC_STEP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pc_q[i] <= BOOT_BASE + PC_W'(i) * BOOT_STRIDE;
      else if (wr_en[i]) pc_q[i] <= pc_d[i];
    end
  end

  assign rd_pc = pc_q[sel_id];
endmodule

// File: rtl/tsc_ctrl_fsm.sv
module tsc_ctrl_fsm
  import tsc_pkg::*;
#(
  parameter int N            = 4,
  parameter int TID_W        = 2,
  parameter int FLUSH_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_valid,
  input  logic [N-1:0]     ret_valid,
  input  logic             gnt_vld,
  input  logic [TID_W-1:0] gnt_id,
  output logic [N-1:0]     ready_now,
  output logic [TID_W-1:0] active_tid,
  output logic             issue_valid,
  output logic             flush,
  output logic             stall,
  output logic             pc_step,
  output logic             pc_load
);
  localparam int CNT_W = $clog2(FLUSH_CYCLES + 1);

  tsc_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [TID_W-1:0] active_q, active_d;
  logic [N-1:0]     wait_q, wait_d;
  logic             flush_q, flush_d;
  logic             take_miss;
  logic             cnt_en, active_en;

  // next-state logic
  always_comb begin
    take_miss = (state_q == ST_RUN) && miss_valid;
    ready_now = ~wait_q | ret_valid;
    wait_d    = (wait_q & ~ret_valid) | (take_miss ? (N'(1) << active_q) : '0);
    state_d   = state_q;
    cnt_d     = cnt_q;
    active_d  = active_q;
    flush_d   = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (take_miss) begin
          state_d = ST_FLUSH;
          cnt_d   = CNT_W'(FLUSH_CYCLES - 1);
          flush_d = 1'b1;
        end
      end
      ST_FLUSH: begin
        if (cnt_q == '0) begin
          if (gnt_vld) begin
            state_d  = ST_RUN;
            active_d = gnt_id;
          end else begin
            state_d = ST_IDLE;
          end
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      ST_IDLE: begin
        if (gnt_vld) begin
          state_d  = ST_RUN;
          active_d = gnt_id;
        end
      end
      default: state_d = ST_RUN;
    endcase
    cnt_en    = (cnt_d != cnt_q);
    active_en = (active_d != active_q);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_RUN;
      cnt_q    <= '0;
      active_q <= '0;
      wait_q   <= '0;
      flush_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wait_q  <= wait_d;
      flush_q <= flush_d;
      if (cnt_en)    cnt_q    <= cnt_d;
      if (active_en) active_q <= active_d;
    end
  end

  assign active_tid  = active_q;
  assign issue_valid = (state_q == ST_RUN);
  assign stall       = (state_q == ST_IDLE);
  assign flush       = flush_q;
  assign pc_step     = issue_valid && !miss_valid;
  assign pc_load     = take_miss;

  a_r3_miss_starts_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && miss_valid) |=> flush);
  a_r3_flush_single: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flush);
  a_r3_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !issue_valid);
  a_r6_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && ret_valid == '0) |=> (stall && !issue_valid));
  a_r4_runner_not_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> !wait_q[active_q]);
  a_r7_return_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid != '0 && !(issue_valid && miss_valid)) |=> ((wait_q & $past(ret_valid)) == '0));
endmodule

// File: rtl/thread_switch_ctrl.sv
module thread_switch_ctrl #(
  parameter int              NTHREADS     = 4,
  parameter int              PC_W         = 32,
  parameter int              FLUSH_CYCLES = 4,
  parameter int              PC_STEP      = 4,
  parameter logic [PC_W-1:0] BOOT_BASE    = 'h1000,
  parameter logic [PC_W-1:0] BOOT_STRIDE  = 'h1000,
  localparam int             TID_W        = (NTHREADS > 1) ? $clog2(NTHREADS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                miss_valid,
  input  logic [PC_W-1:0]     miss_pc,
  input  logic [NTHREADS-1:0] ret_valid,
  output logic [TID_W-1:0]    active_tid,
  output logic [PC_W-1:0]     fetch_pc,
  output logic                issue_valid,
  output logic                flush,
  output logic                stall
);
  logic [NTHREADS-1:0] ready_now;
  logic                gnt_vld;
  logic [TID_W-1:0]    gnt_id;
  logic                pc_step;
  logic                pc_load;

  tsc_ctrl_fsm #(
    .N(NTHREADS), .TID_W(TID_W), .FLUSH_CYCLES(FLUSH_CYCLES)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .ret_valid(ret_valid),
    .gnt_vld(gnt_vld), .gnt_id(gnt_id), .ready_now(ready_now),
    .active_tid(active_tid), .issue_valid(issue_valid), .flush(flush),
    .stall(stall), .pc_step(pc_step), .pc_load(pc_load)
  );

  tsc_rr_pick #(.N(NTHREADS), .TID_W(TID_W)) u_pick (
    .req(ready_now), .last(active_tid), .gnt_vld(gnt_vld), .gnt_id(gnt_id)
  );

  tsc_pc_file #(
    .N(NTHREADS), .PC_W(PC_W), .TID_W(TID_W), .PC_STEP(PC_STEP),
    .BOOT_BASE(BOOT_BASE), .BOOT_STRIDE(BOOT_STRIDE)
  ) u_pcs (
    .clk(clk), .rst_n(rst_n), .step_en(pc_step), .load_en(pc_load),
    .sel_id(active_tid), .load_pc(miss_pc), .rd_pc(fetch_pc)
  );

  a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !miss_valid) |=>
      (issue_valid && $stable(active_tid) && fetch_pc == $past(fetch_pc) + PC_W'(PC_STEP)));
endmodule

// File: tb/sim_thread_switch_ctrl.sv
module sim_thread_switch_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 4;
  localparam int FL = 4;
  localparam logic [31:0] BASE = 32'h1000;
  localparam logic [31:0] STRD = 32'h1000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        miss_valid;
  logic [31:0] miss_pc;
  logic [3:0]  ret_valid;
  logic [1:0]  active_tid;
  logic [31:0] fetch_pc;
  logic        issue_valid, flush, stall;

  int checks = 0;
  int errors = 0;

  // reference model
  logic [31:0] m_pc [NT];
  int          m_state;  // 0 run, 1 flush, 2 idle
  int          m_cnt, m_act;
  logic [3:0]  m_wait;
  bit          m_first, m_switched;
  string       cur_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  thread_switch_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_pc(miss_pc),
    .ret_valid(ret_valid), .active_tid(active_tid), .fetch_pc(fetch_pc),
    .issue_valid(issue_valid), .flush(flush), .stall(stall)
  );

  function automatic int pick(logic [3:0] r, int last);
    for (int k = 1; k <= NT; k++) begin
      int idx = (last + k) % NT;
      if (r[idx]) return idx;
    end
    return -1;
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    string t;
    t = (cur_tag != "") ? cur_tag : tag;
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", t, what, act, exp);
    end
  endtask

  task automatic check_all();
    bit e_issue, e_flush, e_stall;
    e_issue = (m_state == 0);
    e_flush = (m_state == 1) && m_first;
    e_stall = (m_state == 2);
    chk(issue_valid === e_issue, "R3", "issue_valid", 32'(issue_valid), 32'(e_issue));
    chk(flush === e_flush, "R3", "flush", 32'(flush), 32'(e_flush));
    chk(stall === e_stall, "R6", "stall", 32'(stall), 32'(e_stall));
    if (e_issue) begin
      chk(active_tid === 2'(m_act), "R5", "active_tid", 32'(active_tid), 32'(m_act));
      chk(fetch_pc === m_pc[m_act], m_switched ? "R4" : "R2", "fetch_pc", fetch_pc, m_pc[m_act]);
    end
  endtask

  task automatic model_update(bit m, logic [31:0] mpc, logic [3:0] r);
    logic [3:0] rdy, nw;
    int p;
    rdy = ~m_wait | r;
    nw  = m_wait & ~r;
    case (m_state)
      0: begin
        m_switched = 0;
        if (m) begin
          m_pc[m_act] = mpc;
          nw[m_act] = 1'b1;
          m_state = 1; m_cnt = FL - 1; m_first = 1;
        end else begin
          m_pc[m_act] = m_pc[m_act] + 32'd4;
        end
      end
      1: begin
        m_first = 0;
        if (m_cnt == 0) begin
          p = pick(rdy, m_act);
          if (p >= 0) begin m_act = p; m_state = 0; m_switched = 1; end
          else m_state = 2;
        end else m_cnt--;
      end
      default: begin
        p = pick(rdy, m_act);
        if (p >= 0) begin m_act = p; m_state = 0; m_switched = 1; end
      end
    endcase
    m_wait = nw;
  endtask

  // at a falling edge: check, drive, update model, advance one cycle
  task automatic step(bit m, logic [31:0] mpc, logic [3:0] r);
    check_all();
    miss_valid = m; miss_pc = mpc; ret_valid = r;
    model_update(m, mpc, r);
    @(negedge clk);
  endtask

  task automatic miss_when_running(logic [31:0] mpc);
    while (m_state != 0) step(1'b0, 32'h0, 4'h0);
    step(1'b1, mpc, 4'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    rst_n = 1'b0; miss_valid = 1'b0; miss_pc = '0; ret_valid = '0;
    for (int i = 0; i < NT; i++) m_pc[i] = BASE + 32'(i) * STRD;
    m_state = 0; m_cnt = 0; m_act = 0; m_wait = '0; m_first = 0; m_switched = 0;
    cur_tag = "";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    cur_tag = "R1";
    step(1'b0, 32'h0, 4'h0);
    cur_tag = "";
    repeat (3) step(1'b0, 32'h0, 4'h0);

    // R6: every thread misses, nothing returns
    cur_tag = "R6";
    for (int t = 0; t < NT; t++) miss_when_running(32'h8000 + 32'(t) * 32'h40);
    repeat (FL + 4) step(1'b0, 32'h0, 4'h0);
    // return thread 2: resumes at its saved PC (R4)
    cur_tag = "R4";
    step(1'b0, 32'h0, 4'b0100);
    repeat (4) step(1'b0, 32'h0, 4'h0);

    // R8: return for the running (not waiting) thread has no effect
    cur_tag = "R8";
    repeat (3) step(1'b0, 32'h0, 4'b0100);
    // R8: miss during flush is ignored
    step(1'b1, 32'h9000, 4'h0);
    repeat (FL) step(1'b1, 32'hdead0, 4'h0);
    repeat (3) step(1'b0, 32'h0, 4'h0);
    step(1'b0, 32'h0, 4'b0100);
    repeat (3) step(1'b0, 32'h0, 4'h0);

    // R7: miss and a return for another waiting thread in the same cycle
    cur_tag = "R7";
    while (m_state != 0) step(1'b0, 32'h0, 4'h0);
    step(1'b1, 32'ha000, m_wait);
    repeat (FL + 3) step(1'b0, 32'h0, 4'h0);
    miss_when_running(32'ha100);
    while (m_state != 0) step(1'b0, 32'h0, 4'h0);
    step(1'b1, 32'ha200, m_wait & ~(4'b1 << m_act));
    repeat (FL + 3) step(1'b0, 32'h0, 4'h0);

    // R5: return arriving in the last flush cycle counts
    cur_tag = "R5";
    step(1'b0, 32'h0, 4'hf);
    while (m_state != 0) step(1'b0, 32'h0, 4'h0);
    step(1'b1, 32'hb000, 4'h0);
    repeat (FL - 1) step(1'b0, 32'h0, 4'h0);
    step(1'b0, 32'h0, 4'b0001);
    repeat (3) step(1'b0, 32'h0, 4'h0);
    cur_tag = "";

    // seeded random traffic
    for (int n = 0; n < 4000; n++) begin
      bit m;
      logic [3:0] r;
      m = (m_state == 0) ? ($urandom % 6 == 0) : ($urandom % 8 == 0);
      for (int k = 0; k < NT; k++) r[k] = ($urandom % 12 == 0);
      step(m, $urandom & 32'hffff_fffc, r);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule